// File: doc/BRIEF.md
# Extended 64-by-32 Unsigned Divide Unit

This execution unit carries out an extended ordinal divide. A 64-bit unsigned dividend, supplied as two 32-bit words that come from an even/odd register pair, is divided by a 32-bit unsigned divisor. The unit returns a one-word remainder and a one-word quotient to a destination register pair. The remainder goes to the even destination register and the quotient to the register directly above it.

When `start` is pulsed, the unit first screens the operands. The two register numbers must both be even, and the divisor must be nonzero. An operand that fails the screen ends the operation one cycle later with a fault report and no writeback. Valid operands start a restoring shift-subtract division that produces one quotient bit per clock over 64 iterations. A quotient that does not fit in 32 bits raises no fault. The low 32 quotient bits are written, and an informational overflow flag is raised alongside the write.

Top module: `xdiv_unit`

## Requirements
- R1: With valid operands, the dividend is {dvd_hi, dvd_lo} (dvd_hi is the upper 32 bits). rem_data carries that dividend modulo divisor, and quo_data carries the low 32 bits of the dividend divided by divisor.
- R2: On a successful completion, rem_we and quo_we are both high in the single cycle where done is high. In that cycle rem_addr equals the accepted dst_reg and quo_addr equals dst_reg plus one. Neither write enable or fault flag is ever high while done is low.
- R3: If dvd_reg or dst_reg is odd (bit 0 set), done comes with flt_valid high and flt_code = 2'b01, and both write enables stay low.
- R4: If both register numbers are even and the divisor is zero, done comes with flt_valid high and flt_code = 2'b10, and both write enables stay low.
- R5: When an odd register number and a zero divisor occur together, the reported code is 2'b01.
- R6: If dvd_hi >= divisor and the divisor is nonzero, no fault is raised. The writeback still happens with the low 32 quotient bits, and ovf is high in the done cycle. For valid operands with dvd_hi < divisor, ovf is low.
- R7: busy rises one cycle after an accepted start with valid operands and stays high for exactly 64 cycles. done rises 65 cycles after the cycle in which start was driven, in the same cycle that busy falls.
- R8: A faulting start asserts done in the very next cycle, and busy stays low throughout.
- R9: A start pulse received while busy is ignored. It produces no fault, changes no result, and adds no completion.
- R10: While reset is asserted, busy, done, flt_valid, rem_we and quo_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a divide |
| dvd_reg | input | 5 | Register number of the low dividend word |
| dst_reg | input | 5 | Register number of the destination pair |
| divisor | input | 32 | Unsigned divisor |
| dvd_lo | input | 32 | Dividend bits 31:0 |
| dvd_hi | input | 32 | Dividend bits 63:32 |
| busy | output | 1 | Division iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| flt_valid | output | 1 | Completion is a fault |
| flt_code | output | 2 | 01 bad register number, 10 zero divisor |
| ovf | output | 1 | Quotient exceeded 32 bits (information only) |
| rem_we | output | 1 | Remainder write enable |
| rem_addr | output | 5 | Remainder target register |
| rem_data | output | 32 | Remainder value |
| quo_we | output | 1 | Quotient write enable |
| quo_addr | output | 5 | Quotient target register |
| quo_data | output | 32 | Quotient low word |

## Verification
A wrong partial remainder or a lost quotient bit stays hidden until the done cycle. Then it appears as a wrong rem_data or quo_data, so the checks compare every completion against an exact 64-bit model. An iteration counter that is off by one moves done and the fall of busy off the 65-cycle point, and the latency check sees this at once. A corrupted fault latch or a corrupted destination latch shows up in the completion cycle as a write enable beside a fault, a wrong code, or a wrong target register. Starts issued mid-run would show up as extra completions, which the scoreboard would find with no item left to match.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_BADREG  = 2'b01,
    FLT_DIVZERO = 2'b10
  } xdiv_flt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xdiv_st_e;

endpackage

// File: rtl/xdiv_rst_sync.sv
module xdiv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_q_n = hold_q;

endmodule

// File: rtl/xdiv_screen.sv
module xdiv_screen
  import xdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] dvd_reg,
  input  logic [RW-1:0] dst_reg,
  input  logic [DW-1:0] divisor,
  output xdiv_flt_e     fault
);

  logic reg_odd;
  logic dvs_zero;

  assign reg_odd  = dvd_reg[0] | dst_reg[0];
  assign dvs_zero = (divisor == '0);

  // register alignment outranks the zero-divisor test
  always_comb begin
    if (reg_odd)       fault = FLT_BADREG;
    else if (dvs_zero) fault = FLT_DIVZERO;
    else               fault = FLT_NONE;
  end

endmodule

// File: rtl/xdiv_ctrl.sv
module xdiv_ctrl
  import xdiv_pkg::*;
#(
  parameter int DDW = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  xdiv_flt_e fault_in,
  output logic      accept,
  output logic      load,
  output logic      step,
  output logic      busy,
  output logic      done,
  output xdiv_flt_e code
);

  localparam int CW = $clog2(DDW);
  localparam logic [CW-1:0] LAST = CW'(DDW - 1);

  xdiv_st_e      st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  xdiv_flt_e     code_q;
  logic          last;

  assign last   = (cnt_q == LAST);
  assign accept = (st_q == ST_IDLE) && start;
  assign load   = accept && (fault_in == FLT_NONE);
  assign step   = (st_q == ST_RUN);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (fault_in != FLT_NONE) begin
            done_n = 1'b1;
          end else begin
            st_n  = ST_RUN;
            cnt_n = '0;
          end
        end
      end
      ST_RUN: begin
        cnt_n = cnt_q + 1'b1;
        if (last) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      code_q <= FLT_NONE;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      if (accept) code_q <= fault_in;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;
  assign code = code_q;

endmodule

// File: rtl/xdiv_core.sv
module xdiv_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] dvd_lo,
  input  logic [DW-1:0] dvd_hi,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] rem_o,
  output logic [DW-1:0] quo_o,
  output logic          ovf_o
);

  localparam int DDW = 2 * DW;

  logic [DDW-1:0] dq_q, dq_n;
  logic [DW-1:0]  rem_q, rem_n;
  logic [DW-1:0]  dvs_q;
  logic           ovf_q;
  logic [DW:0]    trial;
  logic [DW:0]    diff;
  logic           fits;

  // one restoring iteration: bring in the next dividend bit, try the subtract
  always_comb begin
    trial = {rem_q, dq_q[DDW-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
    rem_n = fits ? diff[DW-1:0] : trial[DW-1:0];
    dq_n  = {dq_q[DDW-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dq_q  <= {dvd_hi, dvd_lo};
      rem_q <= '0;
      dvs_q <= divisor;
      ovf_q <= (dvd_hi >= divisor);
    end else if (step) begin
      dq_q  <= dq_n;
      rem_q <= rem_n;
    end
  end

  assign rem_o = rem_q;
  assign quo_o = dq_q[DW-1:0];
  assign ovf_o = ovf_q;

endmodule

// File: rtl/xdiv_wb.sv
module xdiv_wb
  import xdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          accept,
  input  logic [RW-1:0] dst_reg,
  input  logic          done,
  input  xdiv_flt_e     code,
  input  logic [DW-1:0] rem_i,
  input  logic [DW-1:0] quo_i,
  input  logic          ovf_i,
  output logic          flt_valid,
  output logic [1:0]    flt_code,
  output logic          ovf,
  output logic          rem_we,
  output logic [RW-1:0] rem_addr,
  output logic [DW-1:0] rem_data,
  output logic          quo_we,
  output logic [RW-1:0] quo_addr,
  output logic [DW-1:0] quo_data
);

  logic [RW-1:0] dst_q;
  logic          wr;

  always_ff @(posedge clk) begin
    if (accept) dst_q <= dst_reg;
  end

  always_comb begin
    wr        = done && (code == FLT_NONE);
    flt_valid = done && (code != FLT_NONE);
    flt_code  = flt_valid ? code : FLT_NONE;
    ovf       = wr && ovf_i;
    rem_we    = wr;
    quo_we    = wr;
    rem_addr  = dst_q;
    quo_addr  = dst_q + RW'(1);
    rem_data  = wr ? rem_i : '0;
    quo_data  = wr ? quo_i : '0;
  end

endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit
  import xdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] dvd_reg,
  input  logic [RW-1:0] dst_reg,
  input  logic [DW-1:0] divisor,
  input  logic [DW-1:0] dvd_lo,
  input  logic [DW-1:0] dvd_hi,
  output logic          busy,
  output logic          done,
  output logic          flt_valid,
  output logic [1:0]    flt_code,
  output logic          ovf,
  output logic          rem_we,
  output logic [RW-1:0] rem_addr,
  output logic [DW-1:0] rem_data,
  output logic          quo_we,
  output logic [RW-1:0] quo_addr,
  output logic [DW-1:0] quo_data
);

  localparam int DDW = 2 * DW;

  logic          rst_q_n;
  xdiv_flt_e     fault;
  xdiv_flt_e     code;
  logic          accept;
  logic          load;
  logic          step;
  logic [DW-1:0] rem_w;
  logic [DW-1:0] quo_w;
  logic          ovf_w;

  xdiv_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  xdiv_screen #(.DW(DW), .RW(RW)) u_screen (
    .dvd_reg (dvd_reg),
    .dst_reg (dst_reg),
    .divisor (divisor),
    .fault   (fault)
  );

  xdiv_ctrl #(.DDW(DDW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (start),
    .fault_in (fault),
    .accept   (accept),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .code     (code)
  );

  xdiv_core #(.DW(DW)) u_core (
    .clk     (clk),
    .load    (load),
    .step    (step),
    .dvd_lo  (dvd_lo),
    .dvd_hi  (dvd_hi),
    .divisor (divisor),
    .rem_o   (rem_w),
    .quo_o   (quo_w),
    .ovf_o   (ovf_w)
  );

  xdiv_wb #(.DW(DW), .RW(RW)) u_wb (
    .clk       (clk),
    .accept    (accept),
    .dst_reg   (dst_reg),
    .done      (done),
    .code      (code),
    .rem_i     (rem_w),
    .quo_i     (quo_w),
    .ovf_i     (ovf_w),
    .flt_valid (flt_valid),
    .flt_code  (flt_code),
    .ovf       (ovf),
    .rem_we    (rem_we),
    .rem_addr  (rem_addr),
    .rem_data  (rem_data),
    .quo_we    (quo_we),
    .quo_addr  (quo_addr),
    .quo_data  (quo_data)
  );

endmodule

// File: rtl/xdiv_sva.sv
module xdiv_sva #(
  parameter int RW  = 5,
  parameter int DDW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          flt_valid,
  input logic [1:0]    flt_code,
  input logic          ovf,
  input logic          rem_we,
  input logic [RW-1:0] rem_addr,
  input logic          quo_we,
  input logic [RW-1:0] quo_addr
);

  logic [15:0] bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt_q <= '0;
    else if (busy) bcnt_q <= bcnt_q + 16'd1;
    else           bcnt_q <= '0;
  end

  AST_WE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) rem_we |-> (quo_we && done)); // R2
  AST_ADDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n) rem_we |-> ((quo_addr == rem_addr + RW'(1)) && !rem_addr[0])); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !done |-> (!rem_we && !quo_we && !flt_valid)); // R2
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |-> (!rem_we && !quo_we)); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |-> (flt_code == 2'b01 || flt_code == 2'b10)); // R4
  AST_OVF_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> rem_we); // R6
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done && rem_we)); // R7
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (bcnt_q == 16'(DDW))); // R7
  AST_FAULT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |-> !busy); // R8
  AST_BUSY_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> !flt_valid); // R9

endmodule

bind xdiv_unit xdiv_sva #(.RW(RW), .DDW(DDW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .flt_valid (flt_valid),
  .flt_code  (flt_code),
  .ovf       (ovf),
  .rem_we    (rem_we),
  .rem_addr  (rem_addr),
  .quo_we    (quo_we),
  .quo_addr  (quo_addr)
);

// File: tb/xdiv_unit_bench.sv
module xdiv_unit_bench;

  localparam int DW  = 32;
  localparam int RW  = 5;
  localparam int LAT_OK  = 65;
  localparam int LAT_FLT = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [RW-1:0] dvd_reg, dst_reg;
  logic [DW-1:0] divisor, dvd_lo, dvd_hi;
  logic          busy, done, flt_valid, ovf;
  logic [1:0]    flt_code;
  logic          rem_we, quo_we;
  logic [RW-1:0] rem_addr, quo_addr;
  logic [DW-1:0] rem_data, quo_data;

  always #10 clk = ~clk;

  xdiv_unit #(.DW(DW), .RW(RW)) u_xdiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .dvd_reg(dvd_reg), .dst_reg(dst_reg),
    .divisor(divisor), .dvd_lo(dvd_lo), .dvd_hi(dvd_hi), .busy(busy), .done(done),
    .flt_valid(flt_valid), .flt_code(flt_code), .ovf(ovf), .rem_we(rem_we),
    .rem_addr(rem_addr), .rem_data(rem_data), .quo_we(quo_we), .quo_addr(quo_addr),
    .quo_data(quo_data)
  );

  typedef struct {
    logic          flt;
    logic [1:0]    code;
    logic [DW-1:0] rem;
    logic [DW-1:0] quo;
    logic [RW-1:0] dst;
    logic          ovf;
    int            lat;
    int            scyc;
    string         req;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   done_count = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (!done && (rem_we || quo_we || flt_valid))
        chk(1'b0, "R2", "strobe without done", {rem_we, quo_we, flt_valid}, 0);
      if (done) begin
        done_count++;
        if (sbq.size() == 0) begin
          chk(1'b0, "R9", "completion with no pending item", 1, 0);
        end else begin
          e = sbq.pop_front();
          chk(cyc - e.scyc == e.lat, e.flt ? "R8" : "R7", "latency", cyc - e.scyc, e.lat);
          chk(flt_valid == e.flt, e.req, "flt_valid", flt_valid, e.flt);
          if (e.flt) begin
            chk(flt_code == e.code, e.req, "flt_code", flt_code, e.code);
            chk(!rem_we && !quo_we, e.req, "write enables on fault", {rem_we, quo_we}, 0);
          end else begin
            chk(rem_we && quo_we, "R2", "write enables", {rem_we, quo_we}, 2'b11);
            chk(rem_addr == e.dst, "R2", "rem_addr", rem_addr, e.dst);
            chk(quo_addr == e.dst + 1, "R2", "quo_addr", quo_addr, e.dst + 1);
            chk(rem_data == e.rem, e.req, "remainder", rem_data, e.rem);
            chk(quo_data == e.quo, e.req, "quotient", quo_data, e.quo);
            chk(ovf == e.ovf, "R6", "ovf", ovf, e.ovf);
            chk(!busy, "R7", "busy at done", busy, 0);
          end
        end
      end
    end
  end

  task automatic send(input logic [RW-1:0] s, input logic [RW-1:0] d,
                      input logic [DW-1:0] dv, input logic [DW-1:0] lo,
                      input logic [DW-1:0] hi, input string req);
    exp_t e;
    longint unsigned dd;
    longint unsigned q;
    dd     = {hi, lo};
    e.flt  = s[0] | d[0] | (dv == 0);
    e.code = (s[0] | d[0]) ? 2'b01 : ((dv == 0) ? 2'b10 : 2'b00);
    e.rem  = '0;
    e.quo  = '0;
    if (!e.flt) begin
      q     = dd / longint'(dv);
      e.quo = q[DW-1:0];
      e.rem = DW'(dd % longint'(dv));
    end
    e.ovf = !e.flt && (hi >= dv);
    e.dst = d;
    e.lat = e.flt ? LAT_FLT : LAT_OK;
    e.req = req;
    @(negedge clk);
    start = 1'b1; dvd_reg = s; dst_reg = d; divisor = dv; dvd_lo = lo; dvd_hi = hi;
    e.scyc = cyc;
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == !e.flt, e.flt ? "R8" : "R7", "busy after start", busy, !e.flt);
  endtask

  task automatic wait_done(input int c0);
    for (int i = 0; i < 200 && done_count == c0; i++) @(posedge clk);
    chk(done_count > c0, "R7", "completion seen", done_count - c0, 1);
    @(negedge clk);
  endtask

  task automatic run(input logic [RW-1:0] s, input logic [RW-1:0] d,
                     input logic [DW-1:0] dv, input logic [DW-1:0] lo,
                     input logic [DW-1:0] hi, input string req);
    int c0;
    c0 = done_count;
    send(s, d, dv, lo, hi, req);
    wait_done(c0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; start = 1'b0; dvd_reg = '0; dst_reg = '0;
    divisor = '0; dvd_lo = '0; dvd_hi = '0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !flt_valid && !rem_we && !quo_we, "R10", "outputs in reset",
        {busy, done, flt_valid, rem_we, quo_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run(5'd4, 5'd8, 32'd7, 32'd100, 32'd0, "R1");
    run(5'd0, 5'd2, 32'h0000_1000, 32'h3456_789A, 32'h0000_0012, "R1");
    run(5'd10, 5'd30, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R1");
    run(5'd6, 5'd12, 32'd9, 32'd5, 32'd0, "R1");
    run(5'd2, 5'd4, 32'd3, 32'h0000_0000, 32'd5, "R6");
    run(5'd8, 5'd16, 32'd1, 32'h8765_4321, 32'hFFFF_FFFF, "R6");
    run(5'd3, 5'd4, 32'd7, 32'd50, 32'd0, "R3");
    run(5'd4, 5'd9, 32'd7, 32'd50, 32'd0, "R3");
    run(5'd4, 5'd8, 32'd0, 32'd50, 32'd1, "R4");
    run(5'd5, 5'd8, 32'd0, 32'd50, 32'd0, "R5");
    run(5'd4, 5'd7, 32'd0, 32'd50, 32'd0, "R5");

    // R9: starts during a run are dropped
    c0 = done_count;
    send(5'd14, 5'd20, 32'd13, 32'hDEAD_BEEF, 32'd2, "R9");
    repeat (10) @(negedge clk);
    start = 1'b1; dvd_reg = 5'd1; dst_reg = 5'd3; divisor = '0;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "busy kept after ignored start", busy, 1);
    repeat (5) @(negedge clk);
    start = 1'b1; dvd_reg = 5'd2; dst_reg = 5'd6; divisor = 32'd5; dvd_lo = 32'd1; dvd_hi = 32'd0;
    @(negedge clk);
    start = 1'b0;
    wait_done(c0);
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(done_count == c0 + 1, "R9", "completions after busy starts", done_count - c0, 1);

    run(5'd0, 5'd0, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, "R1");

    chk(sbq.size() == 0, "R9", "scoreboard drained", sbq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule